// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard Controller

This block holds the control state of an in-order pipeline with six stages: instruction fetch, decode, operand address calculation, operand fetch, execute and result write. Instructions come in at the fetch stage as short descriptors. Each descriptor says whether the instruction reads a memory operand, whether it writes a memory result, which register it writes (if any) and which registers it reads, given as a bit mask. Every cycle the controller decides which stages advance and which hold. It inserts idle bubbles and grants the single memory port that instruction fetch, operand fetch and result write all share.

Two kinds of conflict are resolved. The first is contention for the memory port: the oldest requesting instruction always wins, which rules out deadlock. The second is a register read-after-write dependence. The consumer waits in the operand-fetch stage until its producer has left the write stage. A flush input discards everything younger than the execute stage when a branch redirects. Two counters report retired instructions and stall cycles, so cycle totals can be checked.

Top module: `hazard_ctl`

## Requirements
- R1: A valid instruction in a stage that is not held moves to the next stage at the next clock. `adv[i]` is high only for a valid stage i that moves. `stage_valid` bit 0 is fetch and bit 5 is result write.
- R2: With no conflicts and a new descriptor offered every cycle, one instruction retires per cycle. n instructions need n+5 cycles from the first acceptance to the last retirement.
- R3: `mem_grant` is one-hot or zero: bit 0 fetch, bit 1 operand fetch, bit 2 result write. Fetch requests the port whenever it is valid. Operand fetch requests it when valid and the instruction reads memory. Result write requests it when valid and the instruction writes memory. A grant is only given to a requester.
- R4: Among requesters, result write beats operand fetch, and operand fetch beats instruction fetch.
- R5: A stage that requests the port and is refused holds its instruction for that cycle. The stage ahead of it, if it moves on, becomes an idle bubble.
- R6: A held stage also holds every valid stage behind it. Stages ahead of it that are free to move keep advancing.
- R7: An instruction in operand fetch whose read mask contains the destination register of a valid, register-writing instruction in execute or result write holds. It moves on in the cycle after that producer has left result write.
- R8: An invalid stage (a bubble) requests no memory and is never a dependence producer. With the pipeline empty, no grant and no advance are given.
- R9: When `flush` is high, stages 0 to 3 are invalid after the next clock. The instruction leaving operand fetch does not reach execute. `in_ready` is low in a flush cycle. Stages 4 and 5 advance normally.
- R10: `retired_cnt` increments each cycle an instruction leaves result write. `stall_cnt` increments each cycle in which at least one valid stage holds. Both are zero after reset, as are all valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard stages 0 to 3 (branch redirect) |
| in_valid | input | 1 | A descriptor is offered to the fetch stage |
| in_rd_mem | input | 1 | Offered instruction reads a memory operand |
| in_wr_mem | input | 1 | Offered instruction writes a memory result |
| in_wen | input | 1 | Offered instruction writes a register |
| in_wreg | input | $clog2(NREG) | Destination register index |
| in_rmask | input | NREG | Source register mask |
| in_ready | output | 1 | Descriptor is taken at this clock |
| stage_valid | output | 6 | Valid bit per stage, bit 0 fetch |
| adv | output | 6 | Per-stage advance this cycle |
| mem_grant | output | 3 | Memory port grant: fetch, operand, write |
| retire | output | 1 | An instruction completes this cycle |
| retired_cnt | output | CW | Retired-instruction counter |
| stall_cnt | output | CW | Stall-cycle counter |

## Verification
The assertions check, on every cycle, the invariants that need no history of the program. The grant is one-hot and goes only to a requester, and priority runs from the oldest requester down. An advance never lands on a held stage. A stage vacated in front of a held one becomes a bubble. A flush clears the young stages, and the retire counter tracks `retire`. Only the bench's scenarios can show behaviour that depends on timing across several cycles. These are the n+5 cycle total, the exact number of stall cycles a dependence costs, the cycle in which a consumer is released, and that a refused fetch is retried later and not lost. The bench's reference model covers these across directed and random instruction mixes.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int NREG = 8,
  parameter int CW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  input  logic                    in_rd_mem,
  input  logic                    in_wr_mem,
  input  logic                    in_wen,
  input  logic [$clog2(NREG)-1:0] in_wreg,
  input  logic [NREG-1:0]         in_rmask,
  output logic                    in_ready,
  output logic [5:0]              stage_valid,
  output logic [5:0]              adv,
  output logic [2:0]              mem_grant,
  output logic                    retire,
  output logic [CW-1:0]           retired_cnt,
  output logic [CW-1:0]           stall_cnt
);
  localparam int NS = 6;
  localparam int RW = $clog2(NREG);
  localparam int FO = 3;

  logic [NS-1:0] v, rd, wr, we;
  logic [RW-1:0]   wreg [NS];
  logic [NREG-1:0] rm   [NS];
  logic [2:0] mem_req;
  logic [NS-1:0] done;
  logic raw;

  assign mem_req = {v[5] & wr[5], v[FO] & rd[FO], v[0]};
  assign mem_grant = mem_req[2] ? 3'b100 :
                     mem_req[1] ? 3'b010 :
                     mem_req[0] ? 3'b001 : 3'b000;

  assign raw = (v[4] & we[4] & rm[FO][wreg[4]]) |
               (v[5] & we[5] & rm[FO][wreg[5]]);

  assign done[0] = mem_grant[0];
  assign done[1] = 1'b1;
  assign done[2] = 1'b1;
  assign done[3] = (~mem_req[1] | mem_grant[1]) & ~raw;
  assign done[4] = 1'b1;
  assign done[5] = ~mem_req[2] | mem_grant[2];

  assign adv[5] = v[5] & done[5];
  genvar g;
  generate
    for (g = 0; g < NS - 1; g++) begin : g_adv
      assign adv[g] = v[g] & done[g] & (~v[g+1] | adv[g+1]);
    end
  endgenerate

  assign in_ready    = ~flush & (~v[0] | adv[0]);
  assign stage_valid = v;
  assign retire      = adv[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v[0] <= 1'b0;
    end else if (flush) begin
      v[0] <= 1'b0;
    end else if (in_ready && in_valid) begin
      v[0]    <= 1'b1;
      rd[0]   <= in_rd_mem;
      wr[0]   <= in_wr_mem;
      we[0]   <= in_wen;
      wreg[0] <= in_wreg;
      rm[0]   <= in_rmask;
    end else if (adv[0]) begin
      v[0] <= 1'b0;
    end
  end

  generate
    for (g = 1; g < NS; g++) begin : g_stage
      logic kill_own, kill_in;
      assign kill_own = flush & (g <= FO);
      assign kill_in  = flush & (g <= FO + 1);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v[g] <= 1'b0;
        end else if (kill_own) begin
          v[g] <= 1'b0;
        end else if (adv[g-1]) begin
          v[g]    <= ~kill_in;
          rd[g]   <= rd[g-1];
          wr[g]   <= wr[g-1];
          we[g]   <= we[g-1];
          wreg[g] <= wreg[g-1];
          rm[g]   <= rm[g-1];
        end else if (adv[g]) begin
          v[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retired_cnt <= '0;
      stall_cnt   <= '0;
    end else begin
      if (retire) retired_cnt <= retired_cnt + 1'b1;
      if (|(v & ~adv)) stall_cnt <= stall_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [5:0]    stage_valid,
  input logic [5:0]    adv,
  input logic [2:0]    mem_grant,
  input logic [2:0]    mem_req,
  input logic          retire,
  input logic [CW-1:0] retired_cnt
);
  logic [5:0] held, bub;
  assign held = stage_valid & ~adv;
  assign bub  = adv & (held << 1);

  a_r1_adv_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (adv & ~stage_valid) == 6'd0);

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_grant));

  a_r3_grant_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_grant & ~mem_req) == 3'd0);

  a_r4_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req[2] |-> mem_grant[2]);

  a_r4_operand_over_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req[1] && !mem_req[2]) |-> mem_grant[1]);

  a_r6_hold_behind: assert property (@(posedge clk) disable iff (!rst_n)
    ((held >> 1) & adv) == 6'd0);

  a_r5_bubble_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    (bub != 6'd0) |=> (stage_valid & $past(bub)) == 6'd0);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> stage_valid[3:0] == 4'd0);

  a_r10_retire_count: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> retired_cnt == $past(retired_cnt) + 1'b1);

  a_r10_retire_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(retired_cnt));
endmodule

bind hazard_ctl hazard_ctl_chk #(.CW(CW)) u_chk (.*);

// File: tb/hazard_ctl_bench.sv
module hazard_ctl_bench;
  localparam int NREG = 8;
  localparam int CW   = 16;
  localparam int RW   = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0, in_rd_mem = 1'b0, in_wr_mem = 1'b0, in_wen = 1'b0;
  logic [RW-1:0] in_wreg = '0;
  logic [NREG-1:0] in_rmask = '0;
  logic in_ready, retire;
  logic [5:0] stage_valid, adv;
  logic [2:0] mem_grant;
  logic [CW-1:0] retired_cnt, stall_cnt;

  always #2.5 clk = ~clk;

  hazard_ctl #(.NREG(NREG), .CW(CW)) u_hazard_ctl (.*);

  int checks = 0, fails = 0, cyc = 0;

  // program
  int plen, ptr;
  bit p_rd[64], p_wr[64], p_we[64];
  int p_wreg[64], p_rm[64];
  bit fl;

  // reference model state
  bit m_v[6], m_rd[6], m_wr[6], m_we[6];
  int m_wreg[6], m_rm[6];
  int m_ret, m_stall;
  // observation helpers
  int first_acc, last_ret;
  bit saw_fetch_lost, saw_write_first, saw_flush_busy;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic add(input bit rdm, input bit wrm, input bit wen, input int wreg, input int rm);
    p_rd[plen] = rdm; p_wr[plen] = wrm; p_we[plen] = wen;
    p_wreg[plen] = wreg; p_rm[plen] = rm; plen++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fl = 0; plen = 0; ptr = 0;
    for (int i = 0; i < 6; i++) m_v[i] = 0;
    m_ret = 0; m_stall = 0; first_acc = -1; last_ret = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    bit rq_w, rq_o, rq_f, hz, rdy, ok;
    int gr;
    bit go[6];
    bit n_v[6], n_rd[6], n_wr[6], n_we[6];
    int n_wreg[6], n_rm[6];
    logic [5:0] e_sv, e_adv;
    @(negedge clk);
    flush = fl;
    in_valid = (ptr < plen);
    if (ptr < plen) begin
      in_rd_mem = p_rd[ptr]; in_wr_mem = p_wr[ptr]; in_wen = p_we[ptr];
      in_wreg = RW'(p_wreg[ptr]); in_rmask = NREG'(p_rm[ptr]);
    end
    #1;
    rq_w = m_v[5] && m_wr[5];
    rq_o = m_v[3] && m_rd[3];
    rq_f = m_v[0];
    gr = rq_w ? 4 : rq_o ? 2 : rq_f ? 1 : 0;
    hz = 0;
    for (int s = 4; s < 6; s++)
      if (m_v[s] && m_we[s] && m_rm[3][m_wreg[s]]) hz = 1;
    for (int s = 5; s >= 0; s--) begin
      case (s)
        0: ok = (gr == 1);
        3: ok = (!rq_o || gr == 2) && !hz;
        5: ok = (!rq_w || gr == 4);
        default: ok = 1;
      endcase
      go[s] = m_v[s] && ok && (s == 5 || !m_v[s+1] || go[s+1]);
    end
    rdy = !fl && (!m_v[0] || go[0]);
    for (int s = 0; s < 6; s++) begin e_sv[s] = m_v[s]; e_adv[s] = go[s]; end
    check(stage_valid == e_sv, "R1 R9 stage_valid", stage_valid, e_sv);
    check(adv == e_adv, "R1 R5 R6 R7 adv", adv, e_adv);
    check(mem_grant == 3'(gr), "R3 R4 R8 mem_grant", mem_grant, gr);
    check(in_ready == rdy, "R5 R9 in_ready", in_ready, rdy);
    check(retire == go[5], "R2 retire", retire, go[5]);
    check(retired_cnt == CW'(m_ret), "R10 retired_cnt", retired_cnt, m_ret);
    check(stall_cnt == CW'(m_stall), "R10 stall_cnt", stall_cnt, m_stall);
    if (mem_grant == 3'b010 && stage_valid[0] && !adv[0]) saw_fetch_lost = 1;
    if (mem_grant == 3'b100 && stage_valid[3] && !adv[3]) saw_write_first = 1;
    if (fl && in_ready) saw_flush_busy = 1;
    // next state
    for (int s = 0; s < 6; s++) begin
      n_v[s] = m_v[s]; n_rd[s] = m_rd[s]; n_wr[s] = m_wr[s];
      n_we[s] = m_we[s]; n_wreg[s] = m_wreg[s]; n_rm[s] = m_rm[s];
    end
    for (int s = 1; s < 6; s++) begin
      if (go[s]) n_v[s] = 0;
      if (go[s-1]) begin
        n_v[s] = !(fl && s <= 4);
        n_rd[s] = m_rd[s-1]; n_wr[s] = m_wr[s-1]; n_we[s] = m_we[s-1];
        n_wreg[s] = m_wreg[s-1]; n_rm[s] = m_rm[s-1];
      end
      if (fl && s <= 3) n_v[s] = 0;
    end
    if (go[0]) n_v[0] = 0;
    if (rdy && in_valid) begin
      n_v[0] = 1; n_rd[0] = p_rd[ptr]; n_wr[0] = p_wr[ptr]; n_we[0] = p_we[ptr];
      n_wreg[0] = p_wreg[ptr]; n_rm[0] = p_rm[ptr];
      if (first_acc < 0) first_acc = cyc;
      ptr++;
    end
    if (fl) n_v[0] = 0;
    if (go[5]) begin m_ret++; last_ret = cyc; end
    for (int s = 0; s < 6; s++) if (m_v[s] && !go[s]) begin m_stall++; break; end
    @(posedge clk);
    for (int s = 0; s < 6; s++) begin
      m_v[s] = n_v[s]; m_rd[s] = n_rd[s]; m_wr[s] = n_wr[s];
      m_we[s] = n_we[s]; m_wreg[s] = n_wreg[s]; m_rm[s] = n_rm[s];
    end
    cyc++;
  endtask

  task automatic drain();
    int guard = 0;
    bit busy = 1;
    while (busy && guard < 400) begin
      step();
      guard++;
      busy = (ptr < plen);
      for (int s = 0; s < 6; s++) if (m_v[s]) busy = 1;
    end
    step();
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // reset state (R10)
    do_reset();
    #1;
    check(stage_valid == 6'd0, "R10 reset valid", stage_valid, 0);
    check(retired_cnt == '0 && stall_cnt == '0, "R10 reset counters", retired_cnt, 0);

    // R1 R2: 8 plain instructions, no conflicts
    do_reset();
    for (int i = 0; i < 8; i++) add(0, 0, 1, i, 0);
    drain();
    check(last_ret - first_acc == 8 + 5, "R2 n+k-1 cycles", last_ret - first_acc, 13);
    check(stall_cnt == '0, "R2 no stalls", stall_cnt, 0);
    check(retired_cnt == CW'(8), "R2 retired", retired_cnt, 8);

    // R3 R5: operand reads steal the port from fetch
    do_reset();
    saw_fetch_lost = 0;
    for (int i = 0; i < 4; i++) add(1, 0, 0, 0, 0);
    drain();
    check(saw_fetch_lost, "R5 fetch held on operand grant", saw_fetch_lost, 1);
    check(retired_cnt == CW'(4), "R5 all retired", retired_cnt, 4);

    // R4: write result beats operand fetch
    do_reset();
    saw_write_first = 0;
    add(0, 1, 0, 0, 0); add(0, 0, 0, 0, 0); add(1, 0, 0, 0, 0);
    drain();
    check(saw_write_first, "R4 write over operand", saw_write_first, 1);

    // R7: dependent pair costs two stall cycles
    do_reset();
    add(0, 0, 1, 3, 0); add(0, 0, 0, 0, 8'h08);
    drain();
    check(stall_cnt == CW'(2), "R7 dependence stalls", stall_cnt, 2);
    // R8: empty pipe makes no request
    #1;
    check(mem_grant == 3'd0 && adv == 6'd0, "R8 idle no grant", {mem_grant, adv}, 0);

    // R7: independent pair does not stall
    do_reset();
    add(0, 0, 1, 3, 0); add(0, 0, 0, 0, 8'h10);
    drain();
    check(stall_cnt == '0, "R7 no false dependence", stall_cnt, 0);

    // R9: flush in a full pipeline
    do_reset();
    saw_flush_busy = 0;
    for (int i = 0; i < 10; i++) add(0, 0, 0, 0, 0);
    repeat (6) step();
    fl = 1; step(); fl = 0;
    #1;
    check(stage_valid[3:0] == 4'd0, "R9 young stages cleared", stage_valid[3:0], 0);
    check(!saw_flush_busy, "R9 in_ready low in flush", saw_flush_busy, 0);
    drain();
    check(retired_cnt == CW'(m_ret), "R9 retired after flush", retired_cnt, m_ret);

    // mixed random traffic with occasional flush
    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int i = 0; i < 60; i++)
        add($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 7), int'($urandom & $urandom & 32'hff));
      for (int c = 0; c < 150; c++) begin
        fl = ($urandom_range(0, 19) == 0);
        step();
      end
      fl = 0;
      drain();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule